// File: doc/BRIEF.md
# Context-Tagged Translation Cache

This block is a small fully associative cache of virtual-to-physical page translations. Every entry carries a context tag that names the virtual processor which installed it. A lookup only hits an entry whose tag equals the requester's current context, so a change of context does not force the cache to be emptied. Entries also carry a global bit, which one invalidation mode uses to spare them.

A fill port installs translations under the current context. A lookup port returns a registered hit flag and physical page one cycle later. A command port takes selective invalidations: by address and context, by context, of every context except context 0, and by context while sparing global entries. It also takes an address-space root write, which empties the cache only while tagging is switched off. While tagging is off, every entry is installed and looked up as context 0. Each invalidation sweeps all entries in one clock. A done pulse follows a legal command and an error pulse follows an undefined one.

Top module: `ctag_tlb`

## Requirements
- R1: A lookup presented with `lk_valid` gives, one cycle later, `lk_hit`=1 and `lk_ppn` equal to the stored physical page if a valid entry has the same virtual page and a tag equal to the effective context; otherwise `lk_hit`=0 and `lk_ppn`=0. After reset no entry is valid.
- R2: A fill writes under the effective context. If a valid entry with the same virtual page and context exists, that entry is overwritten in place. Otherwise the slot under a round-robin pointer is used. The pointer starts at 0 after reset, advances only on such a new allocation and wraps after the last of the 16 entries.
- R3: Command code 0 invalidates every entry whose virtual page equals `cmd_vpn` and whose tag equals `cmd_tag`.
- R4: Command code 1 invalidates every entry tagged `cmd_tag`. Code 2 invalidates every entry whose tag is non-zero, and entries tagged 0 stay valid.
- R5: Command code 3 invalidates entries tagged `cmd_tag` only when their global bit is clear.
- R6: With `tag_en`=0, the effective context is 0 whatever `cur_tag` holds. Command code 4 (root write) invalidates all entries when `tag_en`=0 and has no effect when `tag_en`=1.
- R7: A command takes effect at the clock edge that accepts it. A lookup in that same cycle sees the earlier contents. `cmd_done` is high for exactly the cycle after a legal command (codes 0 to 4).
- R8: Command codes 5 to 7 change no entry, give no `cmd_done`, and raise `cmd_err` for exactly the following cycle.
- R9: `cmd_busy` is high in every cycle that `cmd_valid` is high, and a fill offered in such a cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_en | input | 1 | Context tagging enable |
| cur_tag | input | 16 | Current context of the requester |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page |
| lk_hit | output | 1 | Registered lookup hit |
| lk_ppn | output | 20 | Registered physical page (0 on miss) |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | 20 | Fill virtual page |
| fill_ppn | input | 20 | Fill physical page |
| fill_global | input | 1 | Global bit of the filled entry |
| cmd_valid | input | 1 | Invalidation command request |
| cmd_op | input | 3 | Command code (0..4 legal) |
| cmd_vpn | input | 20 | Virtual page for code 0 |
| cmd_tag | input | 16 | Context for codes 0, 1, 3 |
| cmd_busy | output | 1 | Command being applied; fills dropped |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle undefined-code pulse |

## Verification
On every cycle the assertions check the command handshake: done follows exactly the legal codes and error exactly the undefined ones. They also check that at most one valid entry matches a lookup, that an idle lookup port never reports a hit, and that a root write with tagging off leaves no entry valid. Which entries survive each selective mode can only be shown by the bench's scenarios. The same holds for the context separation of lookups, in-place refill against round-robin eviction, and the pre-invalidation view of a same-cycle lookup. The bench compares these scenarios with its own model of the entry set.

// File: rtl/ctag_tlb_pkg.sv
package ctag_tlb_pkg;
  typedef enum logic [2:0] {
    OP_ADDR      = 3'd0,
    OP_CTX       = 3'd1,
    OP_ALL       = 3'd2,
    OP_CTX_KEEPG = 3'd3,
    OP_ROOT      = 3'd4
  } inv_op_e;

  function automatic logic op_legal(input logic [2:0] op);
    return op <= 3'd4;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import ctag_tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int TAG_W = 16
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0]            glb,
  input  logic [N-1:0][VPN_W-1:0] vpn_q,
  input  logic [N-1:0][TAG_W-1:0] tag_q,
  input  logic [TAG_W-1:0]        eff_tag,
  input  logic                    tag_en,
  input  logic [VPN_W-1:0]        lk_vpn,
  input  logic [VPN_W-1:0]        fill_vpn,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd_op,
  input  logic [VPN_W-1:0]        cmd_vpn,
  input  logic [TAG_W-1:0]        cmd_tag,
  output logic [N-1:0]            lk_match,
  output logic [N-1:0]            fill_match,
  output logic [N-1:0]            kill
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic ctx_eq;
    assign ctx_eq        = (tag_q[i] == eff_tag);
    assign lk_match[i]   = vld[i] && ctx_eq && (vpn_q[i] == lk_vpn);
    assign fill_match[i] = vld[i] && ctx_eq && (vpn_q[i] == fill_vpn);

    always_comb begin
      kill[i] = 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_ADDR:      kill[i] = (tag_q[i] == cmd_tag) && (vpn_q[i] == cmd_vpn);
          OP_CTX:       kill[i] = (tag_q[i] == cmd_tag);
          OP_ALL:       kill[i] = (tag_q[i] != '0);
          OP_CTX_KEEPG: kill[i] = (tag_q[i] == cmd_tag) && !glb[i];
          OP_ROOT:      kill[i] = !tag_en;
          default:      kill[i] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N    = 16,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (adv)
      ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/ctag_tlb.sv
module ctag_tlb
  import ctag_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int TAG_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tag_en,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_global,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [VPN_W-1:0] cmd_vpn,
  input  logic [TAG_W-1:0] cmd_tag,
  output logic             cmd_busy,
  output logic             cmd_done,
  output logic             cmd_err
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            vld;
  logic [ENTRIES-1:0]            glb;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;

  logic [ENTRIES-1:0] lk_match, fill_match, kill;
  logic [TAG_W-1:0]   eff_tag;
  logic [IW-1:0]      rr_ptr, hit_idx, wr_idx;
  logic               fill_go, alloc;
  logic [PPN_W-1:0]   rd_ppn;

  assign eff_tag  = tag_en ? cur_tag : '0;
  assign cmd_busy = cmd_valid;
  assign fill_go  = fill_valid && !cmd_valid;
  assign alloc    = fill_go && !(|fill_match);

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_match (
    .vld(vld), .glb(glb), .vpn_q(vpn_q), .tag_q(tag_q),
    .eff_tag(eff_tag), .tag_en(tag_en),
    .lk_vpn(lk_vpn), .fill_vpn(fill_vpn),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vpn(cmd_vpn), .cmd_tag(cmd_tag),
    .lk_match(lk_match), .fill_match(fill_match), .kill(kill)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .adv(alloc), .ptr(rr_ptr)
  );

  // index of the entry already holding this page/context (at most one)
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fill_match[i]) hit_idx = IW'(i);
  end
  assign wr_idx = alloc ? rr_ptr : hit_idx;

  // read mux: OR of the single matching entry
  always_comb begin
    rd_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) rd_ppn = rd_ppn | ppn_q[i];
  end

  // valid bits: reset, swept by commands, set by fills
  always_ff @(posedge clk) begin
    if (rst)
      vld <= '0;
    else if (cmd_valid)
      vld <= vld & ~kill;
    else if (fill_go)
      vld[wr_idx] <= 1'b1;
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[wr_idx] <= fill_vpn;
      ppn_q[wr_idx] <= fill_ppn;
      tag_q[wr_idx] <= eff_tag;
      glb[wr_idx]   <= fill_global;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit   <= 1'b0;
      lk_ppn   <= '0;
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      lk_hit   <= lk_valid && (|lk_match);
      lk_ppn   <= lk_valid ? rd_ppn : '0;
      cmd_done <= cmd_valid && op_legal(cmd_op);
      cmd_err  <= cmd_valid && !op_legal(cmd_op);
    end
  end
endmodule

// File: rtl/ctag_tlb_chk.sv
module ctag_tlb_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tag_en,
  input logic         lk_valid,
  input logic         lk_hit,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic         cmd_done,
  input logic         cmd_err,
  input logic [N-1:0] vld,
  input logic [N-1:0] lk_match
);
  // R7: a legal command is followed by done
  a_r7_done_follows: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op <= 3'd4) |=> (cmd_done && !cmd_err));

  // R7: done only ever follows a legal command
  a_r7_done_cause: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> ($past(cmd_valid) && $past(cmd_op) <= 3'd4));

  // R8: undefined code gives error and no done
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op > 3'd4) |=> (cmd_err && !cmd_done));

  // R8: error only after an undefined code
  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> ($past(cmd_valid) && $past(cmd_op) > 3'd4));

  // R6: root write with tagging off empties the cache
  a_r6_root_flush: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd4 && !tag_en) |=> (vld == '0));

  // R2: in-place refill keeps a page/context unique
  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R1: no hit without a lookup request
  a_r1_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_hit);
endmodule

bind ctag_tlb ctag_tlb_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .tag_en(tag_en), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_done(cmd_done), .cmd_err(cmd_err),
  .vld(vld), .lk_match(lk_match)
);

// File: tb/sim_ctag_tlb.sv
module sim_ctag_tlb;
  localparam int N  = 16;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tag_en = 1'b1;
  logic [TW-1:0] cur_tag = '0;
  logic lk_valid = 1'b0, fill_valid = 1'b0, fill_global = 1'b0, cmd_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0, cmd_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [2:0]    cmd_op = '0;
  logic [TW-1:0] cmd_tag = '0;
  logic lk_hit, cmd_busy, cmd_done, cmd_err;
  logic [PW-1:0] lk_ppn;

  always #4 clk = ~clk;  // 125 MHz

  ctag_tlb u0 (
    .clk(clk), .rst(rst), .tag_en(tag_en), .cur_tag(cur_tag),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_global(fill_global), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vpn(cmd_vpn), .cmd_tag(cmd_tag), .cmd_busy(cmd_busy),
    .cmd_done(cmd_done), .cmd_err(cmd_err)
  );

  typedef struct {
    logic          hit;
    logic [PW-1:0] ppn;
    logic          done;
    logic          err;
    string         rq;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;

  // reference model of the entry set
  logic          m_v[N];
  logic          m_g[N];
  logic [VW-1:0] m_vpn[N];
  logic [PW-1:0] m_ppn[N];
  logic [TW-1:0] m_tag[N];
  int            m_ptr = 0;

  task automatic drive(input logic lv, input logic [VW-1:0] lvpn,
                       input logic fv, input logic [VW-1:0] fvpn,
                       input logic [PW-1:0] fppn, input logic fg,
                       input logic cv, input logic [2:0] op,
                       input logic [VW-1:0] cvpn, input logic [TW-1:0] ctag,
                       input string rq);
    exp_t e;
    logic [TW-1:0] et;
    int hi;
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_global = fg;
    cmd_valid = cv; cmd_op = op; cmd_vpn = cvpn; cmd_tag = ctag;
    et = tag_en ? cur_tag : '0;
    e.hit = 1'b0; e.ppn = '0; e.rq = rq;
    if (lv)
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == lvpn && m_tag[i] == et) begin
          e.hit = 1'b1; e.ppn = m_ppn[i];
        end
    e.done = cv && (op <= 3'd4);
    e.err  = cv && (op > 3'd4);
    q.push_back(e);
    #1;
    checks++;
    if (cmd_busy !== cv) begin
      fails++;
      $display("FAIL R9 cmd_busy actual=%0b expected=%0b", cmd_busy, cv);
    end
    if (cv) begin
      for (int i = 0; i < N; i++) begin
        case (op)
          3'd0: if (m_tag[i] == ctag && m_vpn[i] == cvpn) m_v[i] = 1'b0;
          3'd1: if (m_tag[i] == ctag) m_v[i] = 1'b0;
          3'd2: if (m_tag[i] != '0) m_v[i] = 1'b0;
          3'd3: if (m_tag[i] == ctag && !m_g[i]) m_v[i] = 1'b0;
          3'd4: if (!tag_en) m_v[i] = 1'b0;
          default: ;
        endcase
      end
    end else if (fv) begin
      hi = -1;
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == fvpn && m_tag[i] == et) hi = i;
      if (hi < 0) begin
        hi = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_v[hi] = 1'b1; m_g[hi] = fg; m_vpn[hi] = fvpn;
      m_ppn[hi] = fppn; m_tag[hi] = et;
    end
    @(posedge clk);
    #2;
  endtask

  task automatic look(input logic [VW-1:0] v, input string rq);
    drive(1, v, 0, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p,
                      input logic g, input string rq);
    drive(0, 0, 1, v, p, g, 0, 0, 0, 0, rq);
  endtask
  task automatic inv(input logic [2:0] op, input logic [VW-1:0] v,
                     input logic [TW-1:0] t, input string rq);
    drive(0, 0, 0, 0, 0, 0, 1, op, v, t, rq);
  endtask

  // monitor: compare registered outputs after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (lk_hit !== e.hit || lk_ppn !== e.ppn || cmd_done !== e.done || cmd_err !== e.err) begin
        fails++;
        $display("FAIL %s actual hit=%0b ppn=%h done=%0b err=%0b expected hit=%0b ppn=%h done=%0b err=%0b",
                 e.rq, lk_hit, lk_ppn, cmd_done, cmd_err, e.hit, e.ppn, e.done, e.err);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d cycles expected=<20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_tag[i] = '0;
    end
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (lk_hit !== 1'b0 || cmd_done !== 1'b0 || cmd_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual hit=%0b done=%0b err=%0b expected 0 0 0",
               lk_hit, cmd_done, cmd_err);
    end
    look(20'h00A00, "R1 empty after reset");

    // R1: context separation
    tag_en = 1; cur_tag = 16'd5;
    fill(20'h00A00, 20'h11111, 0, "R2 fill ctx5");
    look(20'h00A00, "R1 hit ctx5");
    cur_tag = 16'd6;
    look(20'h00A00, "R1 miss other ctx");
    fill(20'h00A00, 20'h22222, 0, "R2 fill ctx6");
    look(20'h00A00, "R1 hit ctx6");
    cur_tag = 16'd5;
    look(20'h00A00, "R1 ctx5 unchanged");
    // R2: in-place refill
    fill(20'h00A00, 20'h33333, 0, "R2 refill same page");
    look(20'h00A00, "R2 refilled value");

    // R3 with R7 same-cycle lookup
    drive(1, 20'h00A00, 0, 0, 0, 0, 1, 3'd0, 20'h00A00, 16'd5, "R7 lookup sees old state");
    look(20'h00A00, "R3 addr inv removed ctx5");
    cur_tag = 16'd6;
    look(20'h00A00, "R3 addr inv spared ctx6");

    // R4 single context
    fill(20'h00B00, 20'h44444, 0, "R2 fill ctx6 b");
    inv(3'd1, 0, 16'd6, "R4 single ctx");
    look(20'h00A00, "R4 ctx6 page a gone");
    look(20'h00B00, "R4 ctx6 page b gone");

    // R4 all contexts spares tag 0
    cur_tag = 16'd0;
    fill(20'h00C00, 20'h55555, 0, "R2 fill ctx0");
    cur_tag = 16'd9;
    fill(20'h00C00, 20'h66666, 0, "R2 fill ctx9");
    inv(3'd2, 0, 0, "R4 all ctx");
    look(20'h00C00, "R4 ctx9 gone");
    cur_tag = 16'd0;
    look(20'h00C00, "R4 ctx0 kept");

    // R5 retain globals
    cur_tag = 16'd3;
    fill(20'h00D00, 20'h77777, 1, "R2 fill global");
    fill(20'h00E00, 20'h88888, 0, "R2 fill local");
    inv(3'd3, 0, 16'd3, "R5 keep globals");
    look(20'h00D00, "R5 global kept");
    look(20'h00E00, "R5 local gone");

    // R8 undefined code, state intact
    inv(3'd5, 0, 16'd3, "R8 code 5");
    inv(3'd7, 20'h00D00, 16'd3, "R8 code 7");
    look(20'h00D00, "R8 no change");

    // R6 root write with tagging on: no effect
    inv(3'd4, 0, 0, "R6 root write tagged");
    look(20'h00D00, "R6 tagged root no effect");

    // R9 fill during command dropped
    drive(0, 0, 1, 20'h00F00, 20'h99999, 0, 1, 3'd0, 20'h12345, 16'd3, "R9 fill with cmd");
    look(20'h00F00, "R9 fill dropped");

    // R6 tagging off: context 0, root write flushes
    tag_en = 0; cur_tag = 16'd42;
    look(20'h00C00, "R6 untagged sees ctx0");
    fill(20'h01000, 20'hAAAAA, 0, "R6 untagged fill");
    cur_tag = 16'd77;
    look(20'h01000, "R6 untagged any cur_tag");
    inv(3'd4, 0, 0, "R6 root flush");
    look(20'h01000, "R6 flushed page");
    look(20'h00C00, "R6 flushed ctx0");

    // R2 round robin: 17 new pages evict the oldest
    tag_en = 1; cur_tag = 16'd7;
    for (int k = 0; k < N + 1; k++)
      fill(20'h02000 + VW'(k), 20'h30000 + PW'(k), 0, "R2 rr fill");
    look(20'h02000, "R2 oldest evicted");
    look(20'h02001, "R2 second kept");
    look(20'h02010, "R2 newest present");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule